// File: doc/BRIEF.md
# Serial Port With One-Word Line Control

This block is a serial transmitter and receiver for asynchronous character frames. A host talks to it through two word-wide registers selected by one address bit. The data register takes characters to send and hands back received characters, and the line-control word holds the whole line setup. That setup covers the bit-rate divisor, a forced-spacing (break) output, the parity mode, one or two stop bits, the FIFO switch and the character size from 5 to 8 bits. Both directions count sixteen ticks of a divided clock per bit.

Characters queue in a 16-entry FIFO in each direction. When the FIFO switch is off, each queue holds one entry. A received character's error flags are stored next to it in the receive queue, so one read returns the character and the conditions it arrived with. Three level outputs report the state of the port: transmit queue full, receive queue empty, and transmitter busy. An external enable input gates all serial activity.

Top module: `uart_lcr_top`

## Requirements
- R1: The line-control word (reg_sel=1) keeps bits 18:0 of a write and reads back with bits 31:19 zero. Its fields are: divisor in 11:0, break in 12, parity enable in 13, even parity in 14 (odd when clear), two stop bits in 15, FIFO enable in 16 and word length in 18:17.
- R2: Every serial bit lasts exactly 16 × (divisor + 1) clock cycles.
- R3: A transmitted frame has a low start bit, then the data bits LSB first, then one or two high stop bits. Word-length codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R4: With parity enabled, one parity bit follows the last data bit. It is computed over the configured data bits only and gives an even count of ones (even mode) or an odd count (odd mode).
- R5: A data-register read (reg_sel=0) of a non-empty receive queue returns the received character in the low bits, with bits above the word length zero. Bit 8 flags a low first stop bit (frame error), bit 9 a parity mismatch and bit 10 an overrun. The read removes the entry.
- R6: With the FIFO enabled, each queue holds 16 entries. With it disabled, each holds one. tx_full is high when the transmit queue is at capacity, and a data write while it is full is dropped.
- R7: A character that arrives while the receive queue is full is discarded, and bit 10 is set on the newest stored entry.
- R8: tx_busy stays high from a data write until the last stop bit has ended, and falls in the cycle the stop bit ends.
- R9: While the break bit is set and the port is enabled, txd is held low.
- R10: While enable is low, txd is high, data writes are ignored and the receiver ignores the line.
- R11: A data-register read of an empty receive queue returns zero and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Port enable; serial activity only while high |
| reg_sel | input | 1 | Register select: 0 data, 1 line control |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write value |
| rd_en | input | 1 | Read strobe; pops the receive queue when reg_sel=0 |
| rd_data | output | 32 | Read value of the selected register |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_empty | output | 1 | Receive queue holds nothing |
| tx_busy | output | 1 | Transmit queue non-empty or a frame on the wire |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |

## Verification
The bench sweeps all 24 combinations of word length, parity mode and stop-bit count. Under each it decodes two characters from txd at mid-bit and reads them back through a txd-to-rxd loop. A mismatch shows up as a bad field order, a wrong mask or a wrong parity sense. A slower divisor is timed to the exact cycle on the start bit and on the fall of tx_busy, which separates off-by-one errors in the bit counter from errors in the frame length. Hand-driven frames with a low stop bit or a flipped parity bit, overfilled queues in both FIFO modes, break, and the disabled state each bring out one error flag or one blocking rule on its own.

// File: rtl/uart_lcr_pkg.sv
// Shared types and helpers for the serial port: line-control layout,
// state encodings, character size and parity functions.
package uart_lcr_pkg;

    localparam int DIV_W  = 12;
    localparam int CHAR_W = 8;
    localparam int RXW    = CHAR_W + 3;   // char + frame, parity, overrun
    localparam int LCR_W  = DIV_W + 7;
    localparam int OVR_BIT = CHAR_W + 2;

    // Line-control word; field order fixes the bit positions.
    typedef struct packed {
        logic [1:0]       wlen;
        logic             fifo_en;
        logic             two_stop;
        logic             even_par;
        logic             par_en;
        logic             brk;
        logic [DIV_W-1:0] div;
    } lcr_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_state_t;

    // Number of data bits for a word-length code.
    function automatic logic [3:0] data_bits(input logic [1:0] w);
        return 4'd5 + {2'b00, w};
    endfunction

    // Mask of valid data bits for a word-length code.
    function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] w);
        return CHAR_W'(8'hFF >> (2'd3 - w));
    endfunction

    // Parity bit value for already-masked data.
    function automatic logic parity_of(input logic [CHAR_W-1:0] d, input logic even);
        return even ? ^d : ~^d;
    endfunction

endpackage

// File: rtl/uart_lcr_fifo.sv
// Circular queue with a run-time capacity of DEPTH or one entry.
// Assumes callers respect full/empty; blocked pushes and pops are dropped.
// The mark input sets bit MARK_BIT of the newest stored entry.
module uart_lcr_fifo #(
    parameter int WIDTH    = 8,
    parameter int DEPTH    = 16,
    parameter int MARK_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shallow,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    input  logic             mark,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr, newest;
    logic [CW-1:0]    count, cap;
    logic             do_push, do_pop;

    // Capacity and flags.
    always_comb begin
        cap     = shallow ? CW'(1) : DEPTH_C;
        full    = (count >= cap);
        empty   = (count == '0);
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        newest  = (wr_ptr == '0) ? LAST_C : wr_ptr - AW'(1);
        dout    = mem[rd_ptr];
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + AW'(1);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (!do_push && do_pop) count <= count - CW'(1);
        end
    end

    // Storage write and newest-entry flag marking.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
        else if (mark && !empty)
            mem[newest][MARK_BIT] <= 1'b1;
    end

endmodule

// File: rtl/uart_lcr_tx.sv
// Frame transmitter. Advances only on oversampling ticks; each bit spans
// 16 ticks. Assumes the line-control word is stable during a frame.
module uart_lcr_tx
    import uart_lcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  lcr_t              cfg,
    input  logic              have,
    input  logic [CHAR_W-1:0] data,
    output logic              take,
    output logic              line,
    output logic              in_frame
);
    tx_state_t         state;
    logic [3:0]        cnt;
    logic [3:0]        nleft;
    logic [CHAR_W-1:0] shreg;
    logic              par_q;
    logic              stop_more;
    logic [CHAR_W-1:0] masked;

    // Pop request and frame status.
    always_comb begin
        masked   = data & char_mask(cfg.wlen);
        take     = run && tick && (state == TX_IDLE) && have;
        in_frame = (state != TX_IDLE);
    end

    // Frame sequencer and output bit register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state     <= TX_IDLE;
            cnt       <= '0;
            nleft     <= '0;
            shreg     <= '0;
            par_q     <= 1'b0;
            stop_more <= 1'b0;
            line      <= 1'b1;
        end else if (tick) begin
            if (state == TX_IDLE) begin
                if (have) begin
                    shreg <= masked;
                    par_q <= parity_of(masked, cfg.even_par);
                    nleft <= data_bits(cfg.wlen);
                    cnt   <= '0;
                    line  <= 1'b0;
                    state <= TX_START;
                end
            end else if (cnt != 4'd15) begin
                cnt <= cnt + 4'd1;
            end else begin
                cnt <= '0;
                case (state)
                    TX_START: begin
                        line  <= shreg[0];
                        shreg <= shreg >> 1;
                        nleft <= nleft - 4'd2;
                        state <= TX_DATA;
                    end
                    TX_DATA: begin
                        if (nleft != 4'd15) begin
                            line  <= shreg[0];
                            shreg <= shreg >> 1;
                            nleft <= nleft - 4'd1;
                        end else if (cfg.par_en) begin
                            line  <= par_q;
                            state <= TX_PAR;
                        end else begin
                            line      <= 1'b1;
                            stop_more <= cfg.two_stop;
                            state     <= TX_STOP;
                        end
                    end
                    TX_PAR: begin
                        line      <= 1'b1;
                        stop_more <= cfg.two_stop;
                        state     <= TX_STOP;
                    end
                    TX_STOP: begin
                        if (stop_more) stop_more <= 1'b0;
                        else           state     <= TX_IDLE;
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_lcr_rx.sv
// Frame receiver. Detects a falling edge on ticks, confirms the start bit
// 8 ticks later and then samples every 16 ticks at mid-bit. Assumes rxd_s
// is already synchronised. After a low stop bit it waits for a high line.
module uart_lcr_rx
    import uart_lcr_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tick,
    input  lcr_t           cfg,
    input  logic           rxd_s,
    output logic           push,
    output logic [RXW-1:0] word
);
    rx_state_t         state;
    logic [3:0]        cnt;
    logic [3:0]        nleft;
    logic [CHAR_W-1:0] shreg;
    logic [CHAR_W-1:0] aligned;
    logic              par_bad;

    // Right-align the received bits for the configured character size.
    always_comb aligned = shreg >> (4'd8 - data_bits(cfg.wlen));

    // Receive sequencer and result register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            nleft   <= '0;
            shreg   <= '0;
            par_bad <= 1'b0;
            push    <= 1'b0;
            word    <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: if (!rxd_s) begin
                        cnt   <= '0;
                        state <= RX_START;
                    end
                    RX_START: begin
                        if (cnt == 4'd7) begin
                            cnt     <= '0;
                            par_bad <= 1'b0;
                            nleft   <= data_bits(cfg.wlen) - 4'd1;
                            state   <= rxd_s ? RX_IDLE : RX_DATA;
                        end else cnt <= cnt + 4'd1;
                    end
                    RX_DATA: begin
                        if (cnt == 4'd15) begin
                            cnt   <= '0;
                            shreg <= {rxd_s, shreg[CHAR_W-1:1]};
                            if (nleft == '0) state <= cfg.par_en ? RX_PAR : RX_STOP;
                            else             nleft <= nleft - 4'd1;
                        end else cnt <= cnt + 4'd1;
                    end
                    RX_PAR: begin
                        if (cnt == 4'd15) begin
                            cnt     <= '0;
                            par_bad <= (rxd_s != parity_of(aligned, cfg.even_par));
                            state   <= RX_STOP;
                        end else cnt <= cnt + 4'd1;
                    end
                    RX_STOP: begin
                        if (cnt == 4'd15) begin
                            cnt   <= '0;
                            push  <= 1'b1;
                            word  <= {1'b0, par_bad, ~rxd_s, aligned};
                            state <= rxd_s ? RX_IDLE : RX_HOLD;
                        end else cnt <= cnt + 4'd1;
                    end
                    RX_HOLD: if (rxd_s) state <= RX_IDLE;
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_lcr_top.sv
// Serial port top: register decode, line-control register, tick divider,
// input synchroniser, queues and the two frame engines.
// Assumes the host reads rd_data combinationally in the cycle of rd_en.
module uart_lcr_top
    import uart_lcr_pkg::*;
#(
    parameter int BUS_W      = 32,
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [BUS_W-1:0] rd_data,
    output logic             tx_full,
    output logic             rx_empty,
    output logic             tx_busy,
    output logic             txd,
    input  logic             rxd
);
    lcr_t              lcr_q;
    logic [DIV_W-1:0]  bcnt;
    logic              tick;
    logic              rx_meta, rx_sync;
    logic              tx_empty, tx_take, tx_line, tx_frame;
    logic [CHAR_W-1:0] tx_head;
    logic              rx_push, rx_full;
    logic [RXW-1:0]    rx_word, rx_head;

    // Line-control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                lcr_q <= '0;
        else if (wr_en && reg_sel) lcr_q <= lcr_t'(wr_data[LCR_W-1:0]);
    end

    // Oversampling tick divider: one tick every div+1 cycles while enabled.
    always_comb tick = enable && (bcnt == lcr_q.div);
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || tick) bcnt <= '0;
        else                           bcnt <= bcnt + DIV_W'(1);
    end

    // Two-stage synchroniser for the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) {rx_sync, rx_meta} <= 2'b11;
        else        {rx_sync, rx_meta} <= {rx_meta, rxd};
    end

    uart_lcr_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH), .MARK_BIT(0)) u_txq (
        .clk(clk), .rst_n(rst_n), .shallow(~lcr_q.fifo_en),
        .push(wr_en && !reg_sel && enable), .din(wr_data[CHAR_W-1:0]),
        .pop(tx_take), .dout(tx_head), .mark(1'b0),
        .full(tx_full), .empty(tx_empty)
    );

    uart_lcr_tx u_tx (
        .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick), .cfg(lcr_q),
        .have(~tx_empty), .data(tx_head), .take(tx_take),
        .line(tx_line), .in_frame(tx_frame)
    );

    uart_lcr_rx u_rx (
        .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick), .cfg(lcr_q),
        .rxd_s(rx_sync), .push(rx_push), .word(rx_word)
    );

    uart_lcr_fifo #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH), .MARK_BIT(OVR_BIT)) u_rxq (
        .clk(clk), .rst_n(rst_n), .shallow(~lcr_q.fifo_en),
        .push(rx_push), .din(rx_word),
        .pop(rd_en && !reg_sel), .dout(rx_head), .mark(rx_push && rx_full),
        .full(rx_full), .empty(rx_empty)
    );

    // Output line, busy flag and read mux.
    always_comb begin
        txd     = !enable ? 1'b1 : (lcr_q.brk ? 1'b0 : tx_line);
        tx_busy = tx_frame | ~tx_empty;
        if (reg_sel)       rd_data = BUS_W'(lcr_q);
        else if (rx_empty) rd_data = '0;
        else               rd_data = BUS_W'(rx_head);
    end

endmodule

// File: rtl/uart_lcr_chk.sv
// Property checker for the serial port, attached by bind.
module uart_lcr_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             reg_sel,
    input logic             wr_en,
    input logic             rd_en,
    input logic [BUS_W-1:0] rd_data,
    input logic             tx_full,
    input logic             rx_empty,
    input logic             tx_busy,
    input logic             txd,
    input logic [18:0]      lcr_bits
);
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && lcr_bits[12]) |-> !txd); // R9
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> txd); // R10
    AST_FULL_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> tx_busy); // R8
    AST_WRITE_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && enable && !tx_full) |=> tx_busy); // R8
    AST_SINGLE_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !reg_sel && !rx_empty && !lcr_bits[16]) |=> rx_empty); // R6
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel && rx_empty) |-> (rd_data == '0)); // R11
endmodule

bind uart_lcr_top uart_lcr_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .reg_sel(reg_sel),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .tx_full(tx_full),
    .rx_empty(rx_empty), .tx_busy(tx_busy), .txd(txd), .lcr_bits(lcr_q)
);

// File: tb/test_uart_lcr_top.sv
// Self-checking bench: configuration sweep in loopback, exact timing,
// queue limits, error flags, break and disable.
module test_uart_lcr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        tx_full, rx_empty, tx_busy, txd;
    logic        loop_on = 1'b0;
    logic        rxd_drv = 1'b1;
    logic        rxd;
    int          n_chk = 0;
    int          n_err = 0;

    always #2 clk = ~clk;
    assign rxd = loop_on ? txd : rxd_drv;

    uart_lcr_top i_uart_lcr_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_full(tx_full), .rx_empty(rx_empty), .tx_busy(tx_busy),
        .txd(txd), .rxd(rxd)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic set_cfg(input int wl, input int pe, input int ev, input int ts, input int fe, input int dv);
        wr(1'b1, (32'(wl) << 17) | (32'(fe) << 16) | (32'(ts) << 15) |
                 (32'(ev) << 14) | (32'(pe) << 13) | 32'(dv));
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000 && tx_busy; k++) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // Expected line level of frame bit i (0 = start).
    function automatic logic exp_bit(input int i, input int n, input int pe, input int ev, input logic [7:0] d);
        logic [7:0] m;
        m = d & (8'hFF >> (8 - n));
        if (i == 0) return 1'b0;
        if (i <= n) return m[i-1];
        if (pe != 0 && i == n + 1) return ev != 0 ? ^m : ~^m;
        return 1'b1;
    endfunction

    // Samples one frame on txd at mid-bit and compares it.
    task automatic decode(input int n, input int pe, input int ev, input int ts, input int bitp, input logic [7:0] d);
        int nb;
        logic [11:0] got, exp;
        int k;
        nb = 1 + n + pe + 1 + ts;
        got = '0; exp = '0;
        k = 0;
        while (txd !== 1'b0 && k < 50000) begin @(negedge clk); k++; end
        repeat (bitp / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            got[i] = txd;
            exp[i] = exp_bit(i, n, pe, ev, d);
            if (i != nb - 1) repeat (bitp) @(negedge clk);
        end
        check(got == exp, "R3/R4 frame on txd", 32'(got), 32'(exp));
    endtask

    task automatic drive_bits(input logic [11:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk); rxd_drv = b[i];
            repeat (15) @(negedge clk);
        end
        @(negedge clk); rxd_drv = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [7:0]  c0, c1;
        int          lowlen, total, idx, n;
        bit          in_start;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(!tx_full && rx_empty && !tx_busy && txd, "reset flags", {28'b0, tx_full, rx_empty, tx_busy, txd}, 32'h5);
        rd(1'b1, v);
        check(v == 0, "R1 reset control", v, 0);

        // R1: field readback and upper-bit masking
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v);
        check(v == 32'h0007_FFFF, "R1 readback all ones", v, 32'h7FFFF);
        wr(1'b1, 32'h0005_A123);
        rd(1'b1, v);
        check(v == 32'h0005_A123, "R1 readback pattern", v, 32'h5A123);
        wr(1'b1, 32'h0);

        // R3/R4/R5: sweep of all word length, parity and stop combinations
        loop_on = 1'b1;
        idx = 0;
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int ts = 0; ts < 2; ts++) begin
                    n  = 5 + wl;
                    c0 = 8'hA5 ^ 8'(idx * 7);
                    c1 = ~c0 + 8'(idx);
                    set_cfg(wl, pm != 0 ? 1 : 0, pm == 2 ? 1 : 0, ts, 1, 0);
                    wr(1'b0, {24'b0, c0});
                    wr(1'b0, {24'b0, c1});
                    decode(n, pm != 0 ? 1 : 0, pm == 2 ? 1 : 0, ts, 16, c0);
                    decode(n, pm != 0 ? 1 : 0, pm == 2 ? 1 : 0, ts, 16, c1);
                    wait_idle();
                    rd(1'b0, v);
                    check(v == {24'b0, c0 & (8'hFF >> (8 - n))}, "R5 loopback char 0", v, {24'b0, c0 & (8'hFF >> (8 - n))});
                    rd(1'b0, v);
                    check(v == {24'b0, c1 & (8'hFF >> (8 - n))}, "R5 loopback char 1", v, {24'b0, c1 & (8'hFF >> (8 - n))});
                    idx++;
                end
            end
        end
        check(rx_empty, "R5 queue drained by reads", 32'(rx_empty), 1);

        // R2/R8: exact bit period and busy length with divisor 3
        set_cfg(3, 0, 0, 0, 1, 3);
        wr(1'b0, 32'h01);
        for (int k = 0; k < 5000 && txd !== 1'b0; k++) @(negedge clk);
        lowlen = 0; total = 0; in_start = 1'b1;
        while (tx_busy && total < 5000) begin
            if (in_start && txd == 1'b0) lowlen++;
            else in_start = 1'b0;
            total++;
            @(negedge clk);
        end
        check(lowlen == 64, "R2 start bit length", 32'(lowlen), 64);
        check(total == 640, "R8 busy until end of stop", 32'(total), 640);
        repeat (80) @(negedge clk);
        rd(1'b0, v);
        check(v == 32'h01, "R2 loopback at divisor 3", v, 32'h01);

        // R6/R7: deep queues, overrun on the sixteenth stored entry
        set_cfg(3, 0, 0, 0, 1, 0);
        for (int i = 0; i < 17; i++) wr(1'b0, 32'h40 + 32'(i));
        check(tx_full, "R6 transmit queue full at 16", 32'(tx_full), 1);
        wr(1'b0, 32'hEE);
        wait_idle();
        for (int i = 0; i < 16; i++) begin
            rd(1'b0, v);
            check(v == ((i == 15) ? 32'h44F : 32'h40 + 32'(i)), "R7 deep queue contents", v,
                  (i == 15) ? 32'h44F : 32'h40 + 32'(i));
        end
        check(rx_empty, "R7 dropped chars never stored", 32'(rx_empty), 1);

        // R6/R7: single-entry mode
        set_cfg(3, 0, 0, 0, 0, 0);
        wr(1'b0, 32'h11);
        wr(1'b0, 32'h22);
        check(tx_full, "R6 single entry full", 32'(tx_full), 1);
        wr(1'b0, 32'h33);
        wait_idle();
        rd(1'b0, v);
        check(v == 32'h411, "R7 single entry overrun", v, 32'h411);
        check(rx_empty, "R6 single entry after pop", 32'(rx_empty), 1);

        // R5: frame error and parity error on driven frames (8 bits, even)
        loop_on = 1'b0;
        set_cfg(3, 1, 1, 0, 1, 0);
        drive_bits({1'b0, 1'b0, 8'h55, 1'b0}, 11);
        rd(1'b0, v);
        check(v == 32'h155, "R5 frame error flag", v, 32'h155);
        drive_bits({1'b1, 1'b1, 8'h55, 1'b0}, 11);
        rd(1'b0, v);
        check(v == 32'h255, "R5 parity error flag", v, 32'h255);
        drive_bits({1'b1, 1'b1, 8'h54, 1'b0}, 11);
        rd(1'b0, v);
        check(v == 32'h54, "R4 good parity accepted", v, 32'h54);

        // R9: break holds the line low
        set_cfg(3, 0, 0, 0, 1, 0);
        wr(1'b1, 32'h0007_1000);
        total = 0;
        for (int k = 0; k < 50; k++) begin @(negedge clk); if (txd == 1'b0) total++; end
        check(total == 50, "R9 break low", 32'(total), 50);
        wr(1'b1, 32'h0007_0000);
        @(negedge clk);
        check(txd == 1'b1, "R9 line released", 32'(txd), 1);

        // R10: disabled port ignores writes and the line
        @(negedge clk); enable = 1'b0;
        wr(1'b0, 32'h5A);
        check(!tx_busy, "R10 write ignored when off", 32'(tx_busy), 0);
        drive_bits({1'b1, 8'h3C, 1'b0}, 10);
        check(rx_empty, "R10 receive ignored when off", 32'(rx_empty), 1);
        @(negedge clk); enable = 1'b1;
        total = 0;
        for (int k = 0; k < 300; k++) begin @(negedge clk); if (txd == 1'b0) total++; end
        check(total == 0 && !tx_busy && rx_empty, "R10 nothing pending after enable", 32'(total), 0);

        // R11: empty read
        rd(1'b0, v);
        check(v == 0, "R11 empty read value", v, 0);
        check(rx_empty, "R11 empty read no effect", 32'(rx_empty), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule